// File: doc/BRIEF.md
# Three-Source Masked Interrupt Controller

This block gathers the three maskable interrupt causes of a small 8-bit processor system. The first is a one-cycle event pulse from the on-chip timer. The second is a level request from the video controller. The third is a level request from an external pin, which shares its vector with the software break instruction. Software can mask each cause through a disable register. It can read the raw waiting state of every cause through a status register, and it acknowledges the timer by writing any value to the status address.

The block forms a single request line towards the processor core. It also picks the one winning cause by fixed priority and presents that cause's vector address, so the core's interrupt sequencer can fetch the handler pointer directly. Only the timer cause is held inside the block. The two level causes are cleared at their own sources.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the disable register reads 0x00, the timer pending flag is clear, and with both level inputs low the status reads 0x00, `irq_req` is 0, `irq_grant` is 000 and `irq_vector` is 0x0000.
- R2: A write to the disable address (default 0x1402) stores data bits 2:0, which take effect from the next clock. A read of that address returns the stored bits, with bits 7:3 reading 0. A 1 masks the cause and a 0 enables it.
- R3: A read of the status address (default 0x1403) returns bit 0 = external level, bit 1 = video level and bit 2 = timer pending, with bits 7:3 at 0. The level bits follow their inputs in the same cycle. The disable register does not affect this read-out.
- R4: A `timer_evt` pulse sets the timer pending flag from the next clock, and the flag stays set until it is acknowledged.
- R5: A write of any data to the status address clears the timer pending flag from the next clock. It has no effect on the two level bits.
- R6: When a timer event and a status write fall in the same cycle, the timer pending flag ends up set.
- R7: `irq_req` is 1 in the same cycle that any cause is both pending and not masked, and is 0 otherwise.
- R8: `irq_grant` is one-hot or zero. It selects the timer over the video source and the video source over the external one, among unmasked pending causes only.
- R9: `irq_vector` is 0xFFFA for the timer, 0xFFF8 for the video source and 0xFFF6 for the external source, following the grant. It is 0x0000 when nothing is granted.
- R10: Writes to any other address change neither the disable register nor the timer flag. A write to the disable address leaves the timer flag unchanged. Reads of other addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register access address |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| timer_evt | input | 1 | One-cycle timer underflow event |
| irq1_lvl | input | 1 | Video controller request, level |
| irq2_lvl | input | 1 | External/break request, level |
| irq_req | output | 1 | Combined maskable interrupt request |
| irq_grant | output | 3 | One-hot winning cause (bit 2 timer, bit 1 video, bit 0 external) |
| irq_vector | output | 16 | Vector address of the winning cause |

## Verification
The level inputs and the address reach `bus_rdata`, `irq_req`, `irq_grant` and `irq_vector` through logic alone. The bench therefore checks these 1 ns after changing the inputs at a falling edge, within the same cycle. Register writes and timer events go through one flop. The bench applies them for one full cycle between falling edges and checks after the rising edge that captured them. A sweep covers all 64 combinations of mask, timer flag and level inputs, and each expected grant and vector is worked out in the bench from the priority rule.

// File: rtl/irq_mask_pkg.sv
// Package: shared constants for the three-source interrupt controller.
// Assumes the cause order below is the priority order (highest index wins).
package irq_mask_pkg;
    localparam int NUM_SRC   = 3;
    localparam int SRC_EXT   = 0;
    localparam int SRC_VIDEO = 1;
    localparam int SRC_TIMER = 2;

    // Vector for cause idx: two bytes per cause above the base.
    function automatic logic [15:0] src_vector(input logic [15:0] base, input int idx);
        return base + 16'(2 * idx);
    endfunction
endpackage

// File: rtl/irq_mask_regs.sv
// Module: holds the disable mask and the latched timer pending flag.
// Assumes wr_mask and wr_ack are already decoded and never both high.
module irq_mask_regs #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_mask,
    input  logic         wr_ack,
    input  logic [N-1:0] wdata,
    input  logic         timer_evt,
    output logic [N-1:0] mask_q,
    output logic         tmr_pend
);
    // Disable register: loads low bits on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wdata;
    end

    // Timer flag: a new event wins over a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)         tmr_pend <= 1'b0;
        else if (timer_evt) tmr_pend <= 1'b1;
        else if (wr_ack)    tmr_pend <= 1'b0;
    end
endmodule

// File: rtl/irq_mask_prio.sv
// Module: fixed-priority select among active causes and vector lookup.
// Assumes the highest index has the highest priority.
module irq_mask_prio #(
    parameter int          N        = 3,
    parameter logic [15:0] VEC_BASE = 16'hFFF6
) (
    input  logic [N-1:0] active,
    output logic [N-1:0] grant,
    output logic         any,
    output logic [15:0]  vector
);
    logic [N:0] above;

    assign above[N] = 1'b0;

    genvar gi;
    generate
        for (gi = N - 1; gi >= 0; gi--) begin : g_rank
            // Each cause wins only if no higher cause is active.
            assign above[gi] = above[gi+1] | active[gi];
            assign grant[gi] = active[gi] & ~above[gi+1];
        end
    endgenerate

    assign any = above[0];

    // Vector: OR of the granted cause's address (grant is one-hot or zero).
    always_comb begin
        vector = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) vector = vector | irq_mask_pkg::src_vector(VEC_BASE, i);
        end
    end
endmodule

// File: rtl/irq_mask_readmux.sv
// Module: read data select for the disable and status addresses.
// Assumes unknown addresses must read as zero.
module irq_mask_readmux #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                N         = 3,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 16'h1402,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h1403
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      mask_q,
    input  logic [N-1:0]      status,
    output logic [DATA_W-1:0] rdata
);
    // Read mux: zero-extend the addressed field.
    always_comb begin
        rdata = '0;
        if (addr == MASK_ADDR)      rdata = DATA_W'(mask_q);
        else if (addr == STAT_ADDR) rdata = DATA_W'(status);
    end
endmodule

// File: rtl/irq_mask_ctrl.sv
// Module: top of the three-source masked interrupt controller.
// Assumes timer_evt is a single-cycle pulse and level inputs are synchronous.
module irq_mask_ctrl #(
    parameter int                  ADDR_W    = 16,
    parameter int                  DATA_W    = 8,
    parameter logic [ADDR_W-1:0]   MASK_ADDR = 16'h1402,
    parameter logic [ADDR_W-1:0]   STAT_ADDR = 16'h1403,
    parameter logic [15:0]         VEC_BASE  = 16'hFFF6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              timer_evt,
    input  logic              irq1_lvl,
    input  logic              irq2_lvl,
    output logic              irq_req,
    output logic [2:0]        irq_grant,
    output logic [15:0]       irq_vector
);
    import irq_mask_pkg::*;

    localparam int N = NUM_SRC;

    logic         wr_mask;
    logic         wr_ack;
    logic [N-1:0] mask_q;
    logic         tmr_pend;
    logic [N-1:0] status;
    logic [N-1:0] active;
    logic         unused_wdata;

    // Address decode for the two writable locations.
    assign wr_mask = bus_wr && (bus_addr == MASK_ADDR);
    assign wr_ack  = bus_wr && (bus_addr == STAT_ADDR);

    assign unused_wdata = ^bus_wdata[DATA_W-1:N];

    // Raw waiting state in status bit order.
    always_comb begin
        status            = '0;
        status[SRC_EXT]   = irq2_lvl;
        status[SRC_VIDEO] = irq1_lvl;
        status[SRC_TIMER] = tmr_pend;
    end

    assign active = status & ~mask_q;

    irq_mask_regs #(.N(N)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask   (wr_mask),
        .wr_ack    (wr_ack),
        .wdata     (bus_wdata[N-1:0]),
        .timer_evt (timer_evt),
        .mask_q    (mask_q),
        .tmr_pend  (tmr_pend)
    );

    irq_mask_prio #(.N(N), .VEC_BASE(VEC_BASE)) u_prio (
        .active (active),
        .grant  (irq_grant),
        .any    (irq_req),
        .vector (irq_vector)
    );

    irq_mask_readmux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(N),
        .MASK_ADDR(MASK_ADDR), .STAT_ADDR(STAT_ADDR)
    ) u_rmux (
        .addr   (bus_addr),
        .mask_q (mask_q),
        .status (status),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
// Module: assertion checker bound into irq_mask_ctrl.
// Assumes it sees the decoded internal mask and timer flag of the top.
module irq_mask_ctrl_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 16'h1402,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h1403
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              timer_evt,
    input logic [2:0]        mask_q,
    input logic              tmr_pend,
    input logic              irq_req,
    input logic [2:0]        irq_grant,
    input logic [15:0]       irq_vector
);
    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == MASK_ADDR) |=> $stable(mask_q));

    p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        timer_evt |=> tmr_pend);

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == STAT_ADDR && !timer_evt) |=> !tmr_pend);

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_evt && !(bus_wr && bus_addr == STAT_ADDR)) |=> $stable(tmr_pend));

    p_req_matches_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (irq_grant != 3'b000));

    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_grant));

    p_grant_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_grant & mask_q) == 3'b000);

    p_idle_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> irq_vector == 16'h0000);
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
    .ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .timer_evt  (timer_evt),
    .mask_q     (mask_q),
    .tmr_pend   (tmr_pend),
    .irq_req    (irq_req),
    .irq_grant  (irq_grant),
    .irq_vector (irq_vector)
);

// File: tb/irq_mask_ctrl_bench.sv
`timescale 1ns/1ps
module irq_mask_ctrl_bench;
    localparam logic [15:0] A_MASK = 16'h1402;
    localparam logic [15:0] A_STAT = 16'h1403;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        timer_evt = 1'b0;
    logic        irq1_lvl = 1'b0;
    logic        irq2_lvl = 1'b0;
    logic        irq_req;
    logic [2:0]  irq_grant;
    logic [15:0] irq_vector;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_mask_ctrl u_irq_mask_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_evt(timer_evt),
        .irq1_lvl(irq1_lvl), .irq2_lvl(irq2_lvl), .irq_req(irq_req),
        .irq_grant(irq_grant), .irq_vector(irq_vector)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read a register: address set mid-cycle, data checked 1 ns later.
    task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(req, 32'(bus_rdata), 32'(exp));
    endtask

    // One-cycle write, from falling edge to falling edge.
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse_timer();
        @(negedge clk);
        timer_evt = 1'b1;
        @(negedge clk);
        timer_evt = 1'b0;
    endtask

    function automatic logic [15:0] exp_vec(input logic [2:0] g);
        case (g)
            3'b100:  return 16'hFFFA;
            3'b010:  return 16'hFFF8;
            3'b001:  return 16'hFFF6;
            default: return 16'h0000;
        endcase
    endfunction

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_chk("R1 mask", A_MASK, 8'h00);
        rd_chk("R1 status", A_STAT, 8'h00);
        chk("R1 req", 32'(irq_req), 32'd0);
        chk("R1 grant", 32'(irq_grant), 32'd0);
        chk("R1 vector", 32'(irq_vector), 32'h0000);

        // R4: event sets flag, flag holds
        pulse_timer();
        rd_chk("R4 set", A_STAT, 8'h04);
        repeat (5) @(negedge clk);
        rd_chk("R4 hold", A_STAT, 8'h04);

        // R10: other addresses and mask writes leave the flag alone
        wr(16'h1401, 8'hFF);
        wr(16'h1404, 8'hFF);
        rd_chk("R10 mask", A_MASK, 8'h00);
        rd_chk("R10 flag", A_STAT, 8'h04);
        rd_chk("R10 other read", 16'h1401, 8'h00);
        wr(A_MASK, 8'h05);
        rd_chk("R10 flag after mask write", A_STAT, 8'h04);
        wr(A_MASK, 8'h00);

        // R5: ack clears timer only, levels stay
        irq1_lvl = 1'b1; irq2_lvl = 1'b1;
        wr(A_STAT, 8'h5A);
        rd_chk("R5 ack", A_STAT, 8'h03);
        irq1_lvl = 1'b0; irq2_lvl = 1'b0;

        // R6: event and ack in the same cycle
        @(negedge clk);
        bus_addr = A_STAT; bus_wdata = 8'h00; bus_wr = 1'b1; timer_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; timer_evt = 1'b0;
        rd_chk("R6 collide", A_STAT, 8'h04);

        // Sweep: all masks, flag states and levels (R2 R3 R7 R8 R9)
        for (int m = 0; m < 8; m++) begin
            for (int t = 0; t < 2; t++) begin
                for (int lv = 0; lv < 4; lv++) begin
                    logic [2:0] st, act, g;
                    wr(A_STAT, 8'hFF);
                    wr(A_MASK, 8'hF8 | 8'(m));
                    if (t == 1) pulse_timer();
                    irq1_lvl = lv[1]; irq2_lvl = lv[0];
                    st  = {t[0], lv[1], lv[0]};
                    act = st & ~m[2:0];
                    g   = act[2] ? 3'b100 : act[1] ? 3'b010 : act[0] ? 3'b001 : 3'b000;
                    rd_chk("R2 mask readback", A_MASK, 8'(m));
                    rd_chk("R3 status", A_STAT, 8'(st));
                    chk("R7 req", 32'(irq_req), 32'(|act));
                    chk("R8 grant", 32'(irq_grant), 32'(g));
                    chk("R9 vector", 32'(irq_vector), 32'(exp_vec(g)));
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule